// File: doc/BRIEF.md
# Digital Type-II Angle Tracking Loop

This block follows a shaft angle that arrives as a pair of signed, already demodulated sine and cosine samples. It holds its own estimate of the angle in an up/down counter. It looks up the sine and cosine of that estimate in a table, and it forms the phase error sin(theta - phi) as a difference of two products. Two integrators in series turn that error into a position. The first is a saturating velocity accumulator. The second is a phase-accumulator rate generator, which moves the counter by one LSB at a time. Because there are two integrators, the loop settles with no steady-state error on a constant angle and follows a constant rotation rate.

A lead term proportional to the error is added to the rate command, which keeps the loop stable. Limiting the rate command to one step per clock gives the high-frequency roll-off. When the error is close to zero but the sample vector and the estimate point in opposite directions, the loop would otherwise sit still at a false reading half a turn away. A dedicated detector recognises this case and feeds a small positive kick into the velocity accumulator until the loop breaks away.

The outputs are the natural-binary angle word, whose count rises as the input angle rises, and a signed velocity word, which is positive for a rising angle. The angle resolution is a build-time parameter and is meant to be 14 or 16 bits.

Top module: `angle_tracker`

## Requirements
- R1: While reset is held, `angle` is 0 and `velocity` is 0.
- R2: For a constant input angle theta, with amplitude about half of full scale and a sample accepted every cycle, `angle` settles to within 12 LSB of round(theta * 2^ANG_W / 360 degrees), measured on the circle. This holds for angles in all four quadrants.
- R3: After the loop has settled on a constant input, the magnitude of `velocity` is below 2^16.
- R4: `angle` changes by at most one LSB per clock and wraps modulo 2^ANG_W, so a rotation that crosses zero in either direction is tracked through the wrap.
- R5: An input angle that rises steadily gives a rising count and a positive `velocity`. An input angle that falls steadily gives a negative `velocity`. The counter steps up only when the rate command is positive and steps down only when it is negative.
- R6: An instantaneous half-turn step of the input settles to the new angle within the R2 tolerance. This holds from reset, where the error is exactly zero with a negative correlation, and from a settled state.
- R7: The velocity accumulator updates only on the cycle after an accepted sample. While `smp_valid` is low, `velocity` holds its value.
- R8: The velocity accumulator saturates at +/-(2^(VEL_W-1)-1) and does not wrap. During a large step whose error stays positive, `velocity` reaches and holds 2^(VEL_W-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; the sine and cosine inputs are accepted when high |
| sin_smp | input | 16 | Signed sine sample of the shaft angle |
| cos_smp | input | 16 | Signed cosine sample of the shaft angle |
| angle | output | ANG_W (14) | Natural-binary angle estimate, one LSB = 360/2^ANG_W degrees |
| velocity | output | ACC_W+1 (21) | Signed velocity accumulator; one step per clock equals 2^ACC_W |

## Verification
The hardest state to reach from the ports is the false lock at half a turn. At that point the phase error is exactly zero and only the negative correlation shows that the estimate is wrong. A real sensor never produces this, so the stimulus creates it on purpose. It applies an exact 180-degree input straight out of reset, which gives a zero error against the zero estimate. It then applies a second exact half-turn jump after the loop has settled. Saturation is reached by a 170-degree step: the error stays positive while the counter slews at its one-step-per-clock limit, and the velocity word is checked against full scale before the loop arrives.

// File: rtl/trk_pkg.sv
`timescale 1ns/1ps
// Package trk_pkg
// Shared widths and the elaboration-time sine table entry generator for the
// angle tracking loop. Assumes 16-bit signed samples at the loop input.
package trk_pkg;
    localparam int SMP_W  = 16;
    localparam int PROD_W = 2 * SMP_W;
    localparam int DIFF_W = PROD_W + 1;
    localparam int ERR_W  = DIFF_W - (SMP_W - 1);

    // One quarter-wave table entry: round(32767 * sin(pi/2 * idx / 2^qbits)).
    function automatic logic signed [SMP_W-1:0] qsin_entry(input int idx, input int qbits);
        real ang;
        ang = 1.5707963267948966 * real'(idx) / real'(1 << qbits);
        return SMP_W'($rtoi($sin(ang) * 32767.0 + 0.5));
    endfunction
endpackage

// File: rtl/trk_sincos_rom.sv
`timescale 1ns/1ps
// Module trk_sincos_rom
// Returns the sine and cosine of the angle estimate. A quarter-wave table of
// 2^QTR_AW+1 entries is built at elaboration and folded by quadrant. The
// address comes from the top QTR_AW+2 bits of the rounded angle.
// Assumes ANG_W >= QTR_AW + 3.
module trk_sincos_rom
    import trk_pkg::*;
#(
    parameter int ANG_W  = 14,
    parameter int QTR_AW = 10
) (
    input  logic [ANG_W-1:0]        phi,
    output logic signed [SMP_W-1:0] sin_phi,
    output logic signed [SMP_W-1:0] cos_phi
);
    localparam int QN   = 1 << QTR_AW;
    localparam int PH_W = QTR_AW + 2;
    localparam int SH   = ANG_W - PH_W;
    localparam int HALF = 1 << (SH - 1);

    logic signed [SMP_W-1:0] tbl [QN+1];
    logic [PH_W-1:0]         ph_s;
    logic [PH_W-1:0]         ph_c;

    // Quarter-wave table, one constant entry per address.
    for (genvar g = 0; g <= QN; g++) begin : g_tbl
        assign tbl[g] = qsin_entry(g, QTR_AW);
    end

    // Fold a full-circle phase index into the quarter table with sign.
    function automatic logic signed [SMP_W-1:0] fold(input logic [PH_W-1:0] p);
        logic [QTR_AW:0]         i;
        logic signed [SMP_W-1:0] m;
        i = {1'b0, p[QTR_AW-1:0]};
        if (p[QTR_AW]) i = (QTR_AW+1)'(QN) - i;
        m = tbl[i];
        return p[PH_W-1] ? -m : m;
    endfunction

    // Round phi to the table grid; cosine is sine shifted by a quarter turn.
    always_comb begin
        ph_s    = PH_W'((phi + ANG_W'(HALF)) >> SH);
        ph_c    = ph_s + PH_W'(QN);
        sin_phi = fold(ph_s);
        cos_phi = fold(ph_c);
    end
endmodule

// File: rtl/trk_phase_detect.sv
`timescale 1ns/1ps
// Module trk_phase_detect
// Registers the phase error sin(th)cos(ph) - cos(th)sin(ph), scaled by 2^-15,
// for each accepted sample. It also flags a false half-turn lock: the error is
// inside the dead zone while cos(th)cos(ph) + sin(th)sin(ph) is negative.
module trk_phase_detect
    import trk_pkg::*;
#(
    parameter int DEAD_ZONE = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] sin_in,
    input  logic signed [SMP_W-1:0] cos_in,
    input  logic signed [SMP_W-1:0] sin_phi,
    input  logic signed [SMP_W-1:0] cos_phi,
    output logic signed [ERR_W-1:0] err,
    output logic                    err_vld,
    output logic                    hang
);
    localparam logic signed [ERR_W-1:0] DZ = ERR_W'(DEAD_ZONE);

    logic signed [PROD_W-1:0] p_sc, p_cs, p_cc, p_ss;
    logic signed [DIFF_W-1:0] d_err;
    logic signed [ERR_W-1:0]  err_now;
    logic                     cor_neg;
    logic                     near_zero;

    // Cross and dot products of the sample vector with the estimate vector.
    always_comb begin
        p_sc      = sin_in * cos_phi;
        p_cs      = cos_in * sin_phi;
        p_cc      = cos_in * cos_phi;
        p_ss      = sin_in * sin_phi;
        d_err     = DIFF_W'(p_sc) - DIFF_W'(p_cs);
        err_now   = ERR_W'(d_err >>> (SMP_W - 1));
        cor_neg   = (DIFF_W'(p_cc) + DIFF_W'(p_ss)) < 0;
        near_zero = (err_now < DZ) && (err_now > -DZ);
    end

    // Capture the error and the false-lock flag for each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err     <= '0;
            err_vld <= 1'b0;
            hang    <= 1'b0;
        end else begin
            err_vld <= in_valid;
            if (in_valid) begin
                err  <= err_now;
                hang <= near_zero && cor_neg;
            end
        end
    end

    // A flagged false lock always carries a small error.
    AST_HANG_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        hang |-> (err < DZ) && (err > -DZ)); // R6
endmodule

// File: rtl/trk_loop_filter.sv
`timescale 1ns/1ps
// Module trk_loop_filter
// First integrator plus lead: velocity accumulates the error (and the
// false-lock kick) on each valid error. It saturates at +/-(2^(VEL_W-1)-1).
// The rate command is velocity + error*2^LEAD_SH, clipped to the same range.
module trk_loop_filter
    import trk_pkg::*;
#(
    parameter int VEL_W   = 21,
    parameter int LEAD_SH = 10,
    parameter int KICK    = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err,
    input  logic                    err_vld,
    input  logic                    hang,
    output logic signed [VEL_W-1:0] vel,
    output logic signed [VEL_W-1:0] rate
);
    localparam int WIDE = VEL_W + ERR_W + LEAD_SH;
    localparam logic signed [VEL_W-1:0] VMAX   = {1'b0, {(VEL_W-1){1'b1}}};
    localparam logic signed [WIDE-1:0]  KICK_W = WIDE'(KICK);

    logic signed [WIDE-1:0]  kick_add;
    logic signed [WIDE-1:0]  lead;
    logic signed [VEL_W-1:0] vel_nxt;

    // Clip a wide signed value to the symmetric velocity range.
    function automatic logic signed [VEL_W-1:0] clip(input logic signed [WIDE-1:0] x);
        if (x > WIDE'(VMAX))  return VMAX;
        if (x < -WIDE'(VMAX)) return -VMAX;
        return VEL_W'(x);
    endfunction

    // Next velocity and the lead-compensated rate command.
    always_comb begin
        kick_add = hang ? KICK_W : '0;
        lead     = WIDE'(err) <<< LEAD_SH;
        vel_nxt  = clip(WIDE'(vel) + WIDE'(err) + kick_add);
        rate     = clip(WIDE'(vel) + lead);
    end

    // Velocity integrator, advanced only by accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)       vel <= '0;
        else if (err_vld) vel <= vel_nxt;
    end

    AST_VEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(err_vld) |-> vel == $past(vel)); // R7
    AST_VEL_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_vld) && $past(vel) == VMAX && $past(err) >= 0) |-> vel == VMAX); // R8
    AST_VEL_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_vld) && !$past(hang) && $past(vel) == -VMAX && $past(err) <= 0)
        |-> vel == -VMAX); // R8
endmodule

// File: rtl/trk_rate_gen.sv
`timescale 1ns/1ps
// Module trk_rate_gen
// Second integrator. A phase accumulator adds |rate| every clock, and each
// carry moves the angle counter one LSB in the direction of the rate sign.
// The counter wraps modulo 2^ANG_W. Assumes |rate| < 2^ACC_W.
module trk_rate_gen #(
    parameter int ANG_W = 14,
    parameter int ACC_W = 20,
    localparam int VEL_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [VEL_W-1:0] rate,
    output logic [ANG_W-1:0]        phi
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] mag;
    logic [ACC_W:0]   acc_sum;

    // Rate magnitude and accumulator carry.
    always_comb begin
        mag     = rate[VEL_W-1] ? ACC_W'(-rate) : ACC_W'(rate);
        acc_sum = {1'b0, acc} + {1'b0, mag};
    end

    // Accumulate phase and step the up/down angle counter on carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            phi <= '0;
        end else begin
            acc <= acc_sum[ACC_W-1:0];
            if (acc_sum[ACC_W]) phi <= rate[VEL_W-1] ? phi - 1'b1 : phi + 1'b1;
        end
    end

    AST_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (phi == $past(phi)) || (phi == $past(phi) + 1'b1) || (phi == $past(phi) - 1'b1)); // R4
    AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (phi == $past(phi) + 1'b1) |-> $past(rate) > 0); // R5
    AST_DN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (phi == $past(phi) - 1'b1) |-> $past(rate) < 0); // R5
endmodule

// File: rtl/angle_tracker.sv
`timescale 1ns/1ps
// Module angle_tracker
// Type-II digital angle tracking loop. The phase detector feeds a velocity
// integrator with lead, which drives a rate generator that steps the angle
// counter. The sine and cosine of the estimate come from a folded quarter
// table. The inputs are demodulated signed samples with a valid strobe.
module angle_tracker
    import trk_pkg::*;
#(
    parameter int ANG_W     = 14,
    parameter int QTR_AW    = 10,
    parameter int ACC_W     = 20,
    parameter int LEAD_SH   = 10,
    parameter int DEAD_ZONE = 32,
    parameter int KICK      = 64,
    localparam int VEL_W    = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] sin_smp,
    input  logic signed [SMP_W-1:0] cos_smp,
    output logic [ANG_W-1:0]        angle,
    output logic signed [VEL_W-1:0] velocity
);
    logic signed [SMP_W-1:0] sin_phi, cos_phi;
    logic signed [ERR_W-1:0] err;
    logic                    err_vld;
    logic                    hang;
    logic signed [VEL_W-1:0] rate;

    trk_sincos_rom #(.ANG_W(ANG_W), .QTR_AW(QTR_AW)) u_rom (
        .phi(angle), .sin_phi(sin_phi), .cos_phi(cos_phi));

    trk_phase_detect #(.DEAD_ZONE(DEAD_ZONE)) u_pd (
        .clk(clk), .rst_n(rst_n), .in_valid(smp_valid),
        .sin_in(sin_smp), .cos_in(cos_smp),
        .sin_phi(sin_phi), .cos_phi(cos_phi),
        .err(err), .err_vld(err_vld), .hang(hang));

    trk_loop_filter #(.VEL_W(VEL_W), .LEAD_SH(LEAD_SH), .KICK(KICK)) u_lf (
        .clk(clk), .rst_n(rst_n), .err(err), .err_vld(err_vld), .hang(hang),
        .vel(velocity), .rate(rate));

    trk_rate_gen #(.ANG_W(ANG_W), .ACC_W(ACC_W)) u_rg (
        .clk(clk), .rst_n(rst_n), .rate(rate), .phi(angle));
endmodule

// File: tb/sim_angle_tracker.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares them against the outputs at the falling edge.
module sim_angle_tracker;
    localparam int  ANG_W = 14;
    localparam int  FULL  = 1 << ANG_W;
    localparam int  VEL_W = 21;
    localparam int  VMAX  = (1 << (VEL_W - 1)) - 1;
    localparam real AMP   = 16000.0;
    localparam real PI2   = 6.283185307179586;

    localparam int K_ANG_EX = 0, K_VEL_EX = 1, K_ANG_NEAR = 2,
                   K_VEL_POS = 3, K_VEL_NEG = 4, K_VEL_SMALL = 5;

    typedef struct {
        int    kind;
        int    expv;
        int    tol;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [15:0] sin_smp = '0;
    logic signed [15:0] cos_smp = '0;
    logic [ANG_W-1:0] angle;
    logic signed [VEL_W-1:0] velocity;

    item_t sbq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    real   theta = 0.0;

    always #5 clk = ~clk;

    angle_tracker u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .sin_smp(sin_smp), .cos_smp(cos_smp),
        .angle(angle), .velocity(velocity));

    function automatic int wrap_ang(real th);
        int t;
        t = int'(th);
        return ((t % FULL) + FULL) % FULL;
    endfunction

    task automatic drive(real th);
        real r;
        r = th * PI2 / real'(FULL);
        sin_smp = 16'(int'(AMP * $sin(r)));
        cos_smp = 16'(int'(AMP * $cos(r)));
    endtask

    task automatic run(int n, real dth);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            theta = theta + dth;
            drive(theta);
        end
    endtask

    task automatic expect_item(int kind, int ev, int tol, string tag);
        item_t it;
        it.kind = kind; it.expv = ev; it.tol = tol; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    // Monitor: pop expected items and compare with the outputs.
    always @(negedge clk) begin
        item_t it;
        int    a, v, d;
        bit    ok;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            a  = int'(angle);
            v  = int'(velocity);
            ok = 1'b1;
            case (it.kind)
                K_ANG_EX:    ok = (a == it.expv);
                K_VEL_EX:    ok = (v == it.expv);
                K_ANG_NEAR: begin
                    d = ((a - it.expv) % FULL + FULL) % FULL;
                    if (d > FULL / 2) d = FULL - d;
                    ok = (d <= it.tol);
                end
                K_VEL_POS:   ok = (v > 0);
                K_VEL_NEG:   ok = (v < 0);
                K_VEL_SMALL: ok = (v < it.expv) && (v > -it.expv);
                default:     ok = 1'b0;
            endcase
            n_chk++;
            if (!ok) begin
                n_bad++;
                if (it.kind == K_ANG_EX || it.kind == K_ANG_NEAR)
                    $display("FAIL %s: angle actual=%0d expected=%0d (tol %0d)", it.tag, a, it.expv, it.tol);
                else
                    $display("FAIL %s: velocity actual=%0d expected kind %0d value %0d", it.tag, v, it.kind, it.expv);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v0;
        drive(0.0);
        // R1: reset state
        repeat (3) @(posedge clk); #1;
        expect_item(K_ANG_EX, 0, 0, "R1 angle in reset");
        expect_item(K_VEL_EX, 0, 0, "R1 velocity in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R6: exact half turn from reset (zero error, negative correlation)
        theta = 8192.0; drive(theta); smp_valid = 1'b1;
        run(14000, 0.0);
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R6 half turn from reset");
        expect_item(K_VEL_SMALL, 1 << 16, 0, "R3 settled velocity after R6");

        // R2: constant angles in several quadrants
        theta = 30.0 * FULL / 360.0;
        run(14000, 0.0);
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R2 30 deg");
        expect_item(K_VEL_SMALL, 1 << 16, 0, "R3 settled velocity 30 deg");
        theta = 200.0 * FULL / 360.0;
        run(14000, 0.0);
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R2 200 deg");

        // R6: half-turn jump from a settled state
        theta = theta + 8192.0;
        run(14000, 0.0);
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R6 half turn from lock");

        theta = 350.0 * FULL / 360.0;
        run(14000, 0.0);
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R2 350 deg");

        // R5/R4: rising ramp, then across the zero wrap
        run(3000, 0.125);
        expect_item(K_VEL_POS, 0, 0, "R5 rising input gives positive velocity");
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R5 rising ramp tracked");
        run(3000, 0.125);
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R4 upward wrap tracked");

        // R7: velocity holds while samples are not accepted
        smp_valid = 1'b0;
        run(3, 0.125);
        @(negedge clk); v0 = int'(velocity);
        run(40, 0.125);
        expect_item(K_VEL_EX, v0, 0, "R7 velocity held without samples");
        smp_valid = 1'b1;

        // R5/R4: falling ramp across the wrap
        run(7000, -0.125);
        expect_item(K_VEL_NEG, 0, 0, "R5 falling input gives negative velocity");
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R4 downward wrap tracked");

        // R8: 170 deg step keeps the error positive while slewing
        run(8000, 0.0);
        theta = theta + 7737.0;
        run(3000, 0.0);
        expect_item(K_VEL_EX, VMAX, 0, "R8 velocity saturated at full scale");
        run(14000, 0.0);
        expect_item(K_ANG_NEAR, wrap_ang(theta), 12, "R2 after large step");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule